// File: doc/BRIEF.md
# Mesh Node Message Router

This block is the routing front end of a single node in a two-dimensional mesh of compute nodes. It has four neighbour links: north, east, south and west. Each link has an ingress stream and an egress stream, and every stream uses a valid/ready handshake. On each cycle a round-robin arbiter takes at most one message from the ingress streams. The router then compares the message's target coordinates with the node's own position. A message addressed to this node leaves on the internal output. Any other message passes through a bypass channel toward the egress side.

Bypass traffic is merged with messages that the local node emits, and bypass traffic always wins that merge. The merged stream goes through a single forwarding register. That register raises valid on exactly one egress port, chosen by dimension-ordered routing: the column is corrected first (east or west), then the row (north or south). The node's coordinates arrive on static input ports, so every node in the mesh can use the same netlist.

Top module: `mesh_router`

## Requirements
- R1: While reset is held and in the cycle after it is released with no traffic, no egress or internal valid is high, no ingress ready is high, and the local ready is high.
- R2: At most one ingress port completes a handshake in any cycle.
- R3: Ingress ports are served round-robin in index order north(0), east(1), south(2), west(3). The search starts just past the port granted last, and starts at north after reset. With all four ports requesting continuously, grants follow 0,1,2,3,0,... .
- R4: An ingress message whose target row and column equal `node_row`/`node_col` appears only on the internal output. Every other message appears only on an egress port.
- R5: A locally emitted message is accepted only in a cycle in which no bypass message is waiting in the ingress stage, so a continuous bypass stream holds local messages off until it ends.
- R6: When the target column is greater than `node_col` the message leaves on east (index 1). When it is smaller, the message leaves on west (index 3).
- R7: When the target column equals `node_col`, a target row greater than `node_row` leaves on south (index 2) and a smaller row leaves on north (index 0). Row numbers grow southward.
- R8: At most one egress port is valid in any cycle.
- R9: A presented output holds its valid and data unchanged until it is accepted. Every accepted message leaves exactly once, with no loss and no duplication.
- R10: Message layout, with W = ROW_W+COL_W+PAY_W: bits [W-1 -: ROW_W] carry the target row, the next COL_W bits carry the target column, and the low PAY_W bits carry the payload. The payload passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_row | input | ROW_W | Row coordinate of this node (static) |
| node_col | input | COL_W | Column coordinate of this node (static) |
| rx_valid | input | 4 | Ingress valid per neighbour (0=N,1=E,2=S,3=W) |
| rx_data | input | 4 x W | Ingress message per neighbour |
| rx_ready | output | 4 | Ingress ready per neighbour |
| loc_valid | input | 1 | Locally emitted message valid |
| loc_data | input | W | Locally emitted message |
| loc_ready | output | 1 | Local message accepted |
| int_valid | output | 1 | Message for this node valid |
| int_data | output | W | Message for this node |
| int_ready | input | 1 | Node core accepts internal message |
| tx_valid | output | 4 | Egress valid per neighbour |
| tx_data | output | 4 x W | Egress message per neighbour |
| tx_ready | input | 4 | Neighbour accepts egress message |

## Verification
The assertions take four things for granted about the inputs. `node_row` and `node_col` stay constant. A local message never targets the node itself. Each source keeps valid and data steady until its handshake completes. The last two are also written as checks on the local input. The bench drives every source through queues that present a message and hold it until the handshake completes. It draws local targets again until they differ from the node's own address, and it changes the coordinates only while reset is asserted. Random valid and ready gating, including long stretches with every egress blocked, exercises the hold behaviour without ever breaking these rules.

// File: rtl/mr_pkg.sv
package mr_pkg;
  localparam int NPORT   = 4;
  localparam int NPORT_W = 2;

  typedef enum logic [NPORT_W-1:0] {
    DIR_N = 2'd0,
    DIR_E = 2'd1,
    DIR_S = 2'd2,
    DIR_W = 2'd3
  } mr_dir_e;
endpackage

// File: rtl/mr_rr_arbiter.sv
module mr_rr_arbiter #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any_req
);
  logic [IW-1:0] ptr_q, ptr_d;
  int            cand;

  // search starts at the pointer and wraps around
  always_comb begin
    gnt     = '0;
    gnt_idx = ptr_q;
    any_req = 1'b0;
    cand    = 0;
    for (int k = 0; k < N; k++) begin
      cand = (int'(ptr_q) + k) % N;
      if (!any_req && req[cand]) begin
        any_req   = 1'b1;
        gnt_idx   = IW'(cand);
        gnt[cand] = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (gnt_idx == IW'(N-1)) ? '0 : gnt_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/mr_ingress.sv
module mr_ingress
  import mr_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int PAY_W = 16,
  localparam int MW = ROW_W + COL_W + PAY_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ROW_W-1:0]           node_row,
  input  logic [COL_W-1:0]           node_col,
  input  logic [NPORT-1:0]           rx_valid,
  input  logic [NPORT-1:0][MW-1:0]   rx_data,
  output logic [NPORT-1:0]           rx_ready,
  output logic                       int_valid,
  output logic [MW-1:0]              int_data,
  input  logic                       int_ready,
  output logic                       byp_valid,
  output logic [MW-1:0]              byp_data,
  input  logic                       byp_ready
);
  logic [NPORT-1:0]   gnt;
  logic [NPORT_W-1:0] gnt_idx;
  logic               any_req;
  logic [MW-1:0]      sel_d;
  logic               sel_here;
  logic               st_v_q, st_v_d, st_loc_q, st_loc_d;
  logic [MW-1:0]      st_d_q, st_d_d;
  logic               drain, room, load;

  mr_rr_arbiter #(.N(NPORT)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (rx_valid),
    .adv     (load),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any_req (any_req)
  );

  always_comb begin
    sel_d    = rx_data[gnt_idx];
    sel_here = (sel_d[MW-1 -: ROW_W] == node_row) &&
               (sel_d[MW-ROW_W-1 -: COL_W] == node_col);
    drain    = st_v_q && (st_loc_q ? int_ready : byp_ready);
    room     = !st_v_q || drain;
    load     = room && any_req;
    rx_ready = gnt & {NPORT{room}};
  end

  always_comb begin
    st_v_d   = load | (st_v_q & ~drain);
    st_d_d   = load ? sel_d : st_d_q;
    st_loc_d = load ? sel_here : st_loc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_v_q <= 1'b0;
    else        st_v_q <= st_v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_d_q   <= '0;
      st_loc_q <= 1'b0;
    end else if (load) begin
      st_d_q   <= st_d_d;
      st_loc_q <= st_loc_d;
    end
  end

  assign int_valid = st_v_q & st_loc_q;
  assign int_data  = st_d_q;
  assign byp_valid = st_v_q & ~st_loc_q;
  assign byp_data  = st_d_q;
endmodule

// File: rtl/mr_merge.sv
module mr_merge #(
  parameter int MW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byp_valid,
  input  logic [MW-1:0] byp_data,
  output logic          byp_ready,
  input  logic          loc_valid,
  input  logic [MW-1:0] loc_data,
  output logic          loc_ready,
  output logic          fwd_valid,
  output logic [MW-1:0] fwd_data,
  input  logic          fwd_ready
);
  logic          fv_q, fv_d;
  logic [MW-1:0] fd_q, fd_d;
  logic          room, take_b, take_l, load;

  always_comb begin
    room      = !fv_q || fwd_ready;
    byp_ready = room;
    loc_ready = room && !byp_valid;
    take_b    = byp_valid && room;
    take_l    = loc_valid && loc_ready;
    load      = take_b || take_l;
    fv_d      = load | (fv_q & ~fwd_ready);
    fd_d      = take_b ? byp_data : loc_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fv_q <= 1'b0;
    else        fv_q <= fv_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fd_q <= '0;
    else if (load) fd_q <= fd_d;
  end

  assign fwd_valid = fv_q;
  assign fwd_data  = fd_q;
endmodule

// File: rtl/mr_steer.sv
module mr_steer
  import mr_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int PAY_W = 16,
  localparam int MW = ROW_W + COL_W + PAY_W
) (
  input  logic [ROW_W-1:0]         node_row,
  input  logic [COL_W-1:0]         node_col,
  input  logic                     fwd_valid,
  input  logic [MW-1:0]            fwd_data,
  output logic                     fwd_ready,
  output logic [NPORT-1:0]         tx_valid,
  output logic [NPORT-1:0][MW-1:0] tx_data,
  input  logic [NPORT-1:0]         tx_ready
);
  logic [ROW_W-1:0] tgt_row;
  logic [COL_W-1:0] tgt_col;
  mr_dir_e          dir;

  // column first, then row
  always_comb begin
    tgt_row = fwd_data[MW-1 -: ROW_W];
    tgt_col = fwd_data[MW-ROW_W-1 -: COL_W];
    if (tgt_col > node_col)      dir = DIR_E;
    else if (tgt_col < node_col) dir = DIR_W;
    else if (tgt_row > node_row) dir = DIR_S;
    else                         dir = DIR_N;
  end

  always_comb begin
    tx_valid      = '0;
    tx_valid[dir] = fwd_valid;
    fwd_ready     = tx_ready[dir];
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_tx
    assign tx_data[g] = fwd_data;
  end
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import mr_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int PAY_W = 16
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [ROW_W-1:0]                          node_row,
  input  logic [COL_W-1:0]                          node_col,
  input  logic [3:0]                                rx_valid,
  input  logic [3:0][ROW_W+COL_W+PAY_W-1:0]         rx_data,
  output logic [3:0]                                rx_ready,
  input  logic                                      loc_valid,
  input  logic [ROW_W+COL_W+PAY_W-1:0]              loc_data,
  output logic                                      loc_ready,
  output logic                                      int_valid,
  output logic [ROW_W+COL_W+PAY_W-1:0]              int_data,
  input  logic                                      int_ready,
  output logic [3:0]                                tx_valid,
  output logic [3:0][ROW_W+COL_W+PAY_W-1:0]         tx_data,
  input  logic [3:0]                                tx_ready
);
  localparam int MW = ROW_W + COL_W + PAY_W;

  logic          byp_valid, byp_ready;
  logic [MW-1:0] byp_data;
  logic          fwd_valid, fwd_ready;
  logic [MW-1:0] fwd_data;

  mr_ingress #(.ROW_W(ROW_W), .COL_W(COL_W), .PAY_W(PAY_W)) u_ingress (
    .clk       (clk),
    .rst_n     (rst_n),
    .node_row  (node_row),
    .node_col  (node_col),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .int_valid (int_valid),
    .int_data  (int_data),
    .int_ready (int_ready),
    .byp_valid (byp_valid),
    .byp_data  (byp_data),
    .byp_ready (byp_ready)
  );

  mr_merge #(.MW(MW)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .byp_valid (byp_valid),
    .byp_data  (byp_data),
    .byp_ready (byp_ready),
    .loc_valid (loc_valid),
    .loc_data  (loc_data),
    .loc_ready (loc_ready),
    .fwd_valid (fwd_valid),
    .fwd_data  (fwd_data),
    .fwd_ready (fwd_ready)
  );

  mr_steer #(.ROW_W(ROW_W), .COL_W(COL_W), .PAY_W(PAY_W)) u_steer (
    .node_row  (node_row),
    .node_col  (node_col),
    .fwd_valid (fwd_valid),
    .fwd_data  (fwd_data),
    .fwd_ready (fwd_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready)
  );
endmodule

// File: rtl/mr_checker.sv
module mr_checker #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int PAY_W = 16,
  localparam int MW = ROW_W + COL_W + PAY_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ROW_W-1:0]     node_row,
  input logic [COL_W-1:0]     node_col,
  input logic [3:0]           rx_valid,
  input logic [3:0]           rx_ready,
  input logic                 loc_valid,
  input logic [MW-1:0]        loc_data,
  input logic                 loc_ready,
  input logic                 int_valid,
  input logic [MW-1:0]        int_data,
  input logic                 int_ready,
  input logic [3:0]           tx_valid,
  input logic [3:0][MW-1:0]   tx_data,
  input logic [3:0]           tx_ready,
  input logic                 byp_valid
);
  a_r2_one_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_valid & rx_ready));

  for (genvar p = 0; p < 4; p++) begin : g_rr
    a_r3_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid[p] && rx_ready[p]) |=>
        !(rx_valid[p] && rx_ready[p] && ((rx_valid & ~(4'b1 << p)) != 4'b0)));
  end

  a_r4_int_addr: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid |-> (int_data[MW-1 -: ROW_W] == node_row) &&
                  (int_data[MW-ROW_W-1 -: COL_W] == node_col));

  // input rule: the node never emits to itself
  a_r4_loc_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid |-> !((loc_data[MW-1 -: ROW_W] == node_row) &&
                    (loc_data[MW-ROW_W-1 -: COL_W] == node_col)));

  a_r5_bypass_first: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && loc_ready) |-> !byp_valid);

  a_r6_east: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid[1] |-> (tx_data[1][MW-ROW_W-1 -: COL_W] > node_col));

  a_r6_west: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid[3] |-> (tx_data[3][MW-ROW_W-1 -: COL_W] < node_col));

  a_r7_south: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid[2] |-> (tx_data[2][MW-ROW_W-1 -: COL_W] == node_col) &&
                    (tx_data[2][MW-1 -: ROW_W] > node_row));

  a_r7_north: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid[0] |-> (tx_data[0][MW-ROW_W-1 -: COL_W] == node_col) &&
                    (tx_data[0][MW-1 -: ROW_W] < node_row));

  a_r8_one_egress: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_valid));

  a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_valid & ~tx_ready) != 4'b0) |=> $stable(tx_valid) && $stable(tx_data));

  a_r9_int_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && !int_ready) |=> int_valid && $stable(int_data));

  a_r9_loc_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && loc_ready) |=> (tx_valid != 4'b0));

  // input rule: a local message waiting for ready is held steady
  a_r9_loc_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && !loc_ready) |=> loc_valid && $stable(loc_data));
endmodule

bind mesh_router mr_checker #(.ROW_W(ROW_W), .COL_W(COL_W), .PAY_W(PAY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .node_row  (node_row),
  .node_col  (node_col),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .loc_valid (loc_valid),
  .loc_data  (loc_data),
  .loc_ready (loc_ready),
  .int_valid (int_valid),
  .int_data  (int_data),
  .int_ready (int_ready),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .tx_ready  (tx_ready),
  .byp_valid (byp_valid)
);

// File: tb/mesh_router_tb.sv
module mesh_router_tb;
  localparam int RW = 4, CW = 4, PW = 16;
  localparam int MW = RW + CW + PW;
  localparam int MYR = 5, MYC = 5;
  localparam int MAXID = 4096;

  logic               clk, rst_n;
  logic [RW-1:0]      node_row;
  logic [CW-1:0]      node_col;
  logic [3:0]         rx_valid, rx_ready;
  logic [3:0][MW-1:0] rx_data;
  logic               loc_valid, loc_ready;
  logic [MW-1:0]      loc_data;
  logic               int_valid, int_ready;
  logic [MW-1:0]      int_data;
  logic [3:0]         tx_valid, tx_ready;
  logic [3:0][MW-1:0] tx_data;

  mesh_router #(.ROW_W(RW), .COL_W(CW), .PAY_W(PW)) u_dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int next_id = 0, injected = 0, delivered = 0, ord_cnt = 0;
  int exp_exit [MAXID];
  int seen     [MAXID];
  int dlv_ord  [MAXID];
  logic [MW-1:0] srcq [5][$];
  logic [4:0] pres;
  int in_rate = 100, loc_rate = 100, rdy_rate = 100, int_rate = 100;
  int rr_seq [64];
  int rr_n = 0;
  bit rr_log = 0;
  logic [3:0]         p_txv, p_txr;
  logic [3:0][MW-1:0] p_txd;
  logic               p_iv, p_ir;
  logic [MW-1:0]      p_id;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_port(input int r, input int c);
    if (r == MYR && c == MYC) return 4;
    if (c > MYC) return 1;
    if (c < MYC) return 3;
    if (r > MYR) return 2;
    return 0;
  endfunction

  task automatic push_msg(input int src, input int r, input int c);
    logic [MW-1:0] m;
    int id;
    id = next_id;
    next_id++;
    exp_exit[id] = exp_port(r, c);
    seen[id] = 0;
    m = {r[RW-1:0], c[CW-1:0], src[3:0], id[11:0]};
    srcq[src].push_back(m);
  endtask

  task automatic deliver(input int port, input logic [MW-1:0] d);
    int id, ex;
    string tag;
    id = int'(d[11:0]);
    ex = exp_exit[id];
    if (ex == 4) tag = "R4 internal";
    else if (ex == 1 || ex == 3) tag = "R6 column";
    else tag = "R7 row";
    chk(seen[id] == 0, "R9 duplicate", seen[id], 0);
    chk(port == ex, tag, port, ex);
    seen[id]++;
    dlv_ord[id] = ord_cnt;
    ord_cnt++;
    delivered++;
    if (rr_log && port == 4 && rr_n < 64) begin
      rr_seq[rr_n] = int'(d[15:12]);
      rr_n++;
    end
  endtask

  task automatic drive();
    for (int s = 0; s < 5; s++) begin
      if (!pres[s] && srcq[s].size() > 0 &&
          ($urandom % 100) < ((s == 4) ? loc_rate : in_rate))
        pres[s] = 1'b1;
    end
    for (int p = 0; p < 4; p++) begin
      rx_valid[p] = pres[p];
      rx_data[p]  = pres[p] ? srcq[p][0] : '0;
      tx_ready[p] = ($urandom % 100) < rdy_rate;
    end
    loc_valid = pres[4];
    loc_data  = pres[4] ? srcq[4][0] : '0;
    int_ready = ($urandom % 100) < int_rate;
  endtask

  task automatic sample();
    // R9: a stalled output keeps valid and data
    if ((p_txv & ~p_txr) != 4'b0) begin
      chk(tx_valid == p_txv, "R9 tx valid hold", int'(tx_valid), int'(p_txv));
      chk(tx_data == p_txd, "R9 tx data hold", int'(tx_data[0][11:0]), int'(p_txd[0][11:0]));
    end
    if (p_iv && !p_ir)
      chk(int_valid && int_data == p_id, "R9 int hold", int'(int_data[11:0]), int'(p_id[11:0]));
    chk($countones(tx_valid) <= 1, "R8 one egress", $countones(tx_valid), 1);
    chk($countones(rx_valid & rx_ready) <= 1, "R2 one accept", $countones(rx_valid & rx_ready), 1);
    for (int p = 0; p < 4; p++) begin
      if (rx_valid[p] && rx_ready[p]) begin
        void'(srcq[p].pop_front());
        pres[p] = 1'b0;
        injected++;
      end
      if (tx_valid[p] && tx_ready[p]) deliver(p, tx_data[p]);
    end
    if (loc_valid && loc_ready) begin
      void'(srcq[4].pop_front());
      pres[4] = 1'b0;
      injected++;
    end
    if (int_valid && int_ready) deliver(4, int_data);
    p_txv = tx_valid; p_txr = tx_ready; p_txd = tx_data;
    p_iv = int_valid; p_ir = int_ready; p_id = int_data;
  endtask

  task automatic cyc();
    drive();
    #1;
    sample();
    @(negedge clk);
  endtask

  function automatic bit pending();
    for (int s = 0; s < 5; s++) if (srcq[s].size() > 0) return 1;
    return (injected != delivered);
  endfunction

  task automatic drain();
    int n;
    in_rate = 100; loc_rate = 100; rdy_rate = 100; int_rate = 100;
    n = 0;
    while (pending() && n < 3000) begin
      cyc();
      n++;
    end
    chk(!pending(), "R9 drained", injected - delivered, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r, c, b0, lid, maxb;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; node_row = RW'(MYR); node_col = CW'(MYC);
    rx_valid = '0; rx_data = '0; loc_valid = 1'b0; loc_data = '0;
    int_ready = 1'b0; tx_ready = '0; pres = '0;
    p_txv = '0; p_txr = '0; p_txd = '0; p_iv = 1'b0; p_ir = 1'b0; p_id = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(tx_valid == 4'b0 && int_valid == 1'b0, "R1 valids in reset", int'({tx_valid, int_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(tx_valid == 4'b0, "R1 tx idle", int'(tx_valid), 0);
    chk(int_valid == 1'b0, "R1 int idle", int'(int_valid), 0);
    chk(rx_ready == 4'b0, "R1 rx ready low", int'(rx_ready), 0);
    chk(loc_ready == 1'b1, "R1 loc ready", int'(loc_ready), 1);
    @(negedge clk);

    // R3: all four ports stream messages for this node
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < 4; p++) push_msg(p, MYR, MYC);
    rr_log = 1;
    drain();
    rr_log = 0;
    chk(rr_n == 32, "R3 grant count", rr_n, 32);
    for (int k = 0; k < 32; k++)
      chk(rr_seq[k] == k % 4, "R3 round robin order", rr_seq[k], k % 4);

    // R5: continuous bypass stream versus one local message
    b0 = next_id;
    for (int k = 0; k < 10; k++) push_msg(0, MYR, MYC + 1);
    lid = next_id;
    push_msg(4, MYR, MYC - 1);
    loc_rate = 0;
    cyc(); cyc();
    loc_rate = 100;
    drain();
    maxb = 0;
    for (int k = b0; k < b0 + 10; k++) if (dlv_ord[k] > maxb) maxb = dlv_ord[k];
    chk(dlv_ord[lid] > maxb, "R5 bypass wins merge", dlv_ord[lid], maxb + 1);

    // R6 R7 R4 R10: direction corners
    push_msg(0, MYR, MYC + 1);  push_msg(1, MYR, MYC - 1);
    push_msg(2, MYR + 1, MYC);  push_msg(3, MYR - 1, MYC);
    push_msg(0, 0, 15);         push_msg(1, 15, 0);
    push_msg(2, 0, MYC);        push_msg(3, 15, MYC);
    push_msg(0, MYR, MYC);      push_msg(4, 0, 0);
    push_msg(4, 15, MYC);       push_msg(4, 0, MYC);
    drain();

    // R9: every output blocked for a while
    for (int k = 0; k < 8; k++) push_msg(k % 5, (k * 3) % 16, (k * 7) % 16 == MYC ? 0 : (k * 7) % 16);
    rdy_rate = 0; int_rate = 0;
    repeat (20) cyc();
    drain();

    // random traffic
    for (int k = 0; k < 600; k++) push_msg($urandom % 4, $urandom % 16, $urandom % 16);
    for (int k = 0; k < 150; k++) begin
      do begin
        r = $urandom % 16;
        c = $urandom % 16;
      end while (r == MYR && c == MYC);
      push_msg(4, r, c);
    end
    in_rate = 60; loc_rate = 50; rdy_rate = 60; int_rate = 60;
    for (int n = 0; n < 20000 && pending(); n++) cyc();
    drain();

    for (int id = 0; id < next_id; id++)
      chk(seen[id] == 1, "R9 exactly once", seen[id], 1);
    chk(injected == next_id, "R9 all injected", injected, next_id);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule